// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block is a byte-wide input port that sits between a peripheral and a CPU bus. The peripheral puts a byte on the port pins and pulses an active-low strobe. The falling strobe, seen through a synchronizer, copies the pins into a holding latch and raises a buffer-full flag. While that flag is high the peripheral must wait, and the block ignores any further strobes. The CPU collects the byte with an ordinary active-low read of the data address. The falling edge of that read withdraws the interrupt. The rising edge, which ends the read, empties the buffer.

A maskable interrupt supports interrupt-driven operation. A status byte on a second address supports polling. The mask flip-flop and two general-purpose lines are set up by single-byte writes to the control address. Each write either sets or clears one selected bit, or sets the direction of the general-purpose lines. Both asynchronous strobes pass through a synchronizer chain, and their edges are found by comparing each one with a registered copy.

Top module: `strb_in_port`

## Requirements
- R1: After reset the buffer-full flag, the interrupt and the mask flip-flop are 0, and the general-purpose lines are inputs (gpOe = 0). A status read then returns gpIn in bits 7:6 and zeros in bits 5:0.
- R2: A falling edge on stbN while the buffer is empty captures pinData. A read with csN low and addr = 00 returns that byte on rdData.
- R3: The buffer-full flag rises within a few cycles after stbN falls. It stays high through the whole of a data read and clears after rdN returns high.
- R4: A strobe that arrives while the buffer-full flag is high is ignored, and the latched byte is unchanged.
- R5: The interrupt is high only when stbN is released (high), the buffer is full and the mask flip-flop is 1. It stays low while stbN is held low, even with a full buffer.
- R6: The interrupt clears soon after rdN falls for a data read. It does so while the buffer-full flag is still high.
- R7: While the mask flip-flop is 0, no interrupt is produced.
- R8: A write (wrEn pulse, csN low, addr = 11) with bit 7 = 0 and bits 3:1 = 4 loads bit 0 into the mask flip-flop.
- R9: A read with csN low and addr = 10 returns the status byte, which the read leaves unchanged, and does not clear the buffer. The status byte holds the general-purpose line levels in bits 7:6, the buffer-full flag in bit 5, the mask in bit 4, the interrupt in bit 3 and zeros in bits 2:0.
- R10: A control write with bit 7 = 1 sets the direction of the general-purpose lines from bit 3 (1 = input, 0 = output; gpOe = 1 for output). With bit 7 = 0, bits 3:1 = 6 or 7 write bit 0 into gpOut[0] or gpOut[1]. In output mode the status bits 7:6 show gpOut.
- R11: A read strobe with csN high neither clears the buffer-full flag nor clears the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinData | input | 8 | Byte presented by the peripheral |
| stbN | input | 1 | Active-low capture strobe from the peripheral |
| ibfOut | output | 1 | Buffer-full flag to the peripheral |
| intrOut | output | 1 | Interrupt request to the CPU |
| csN | input | 1 | Active-low chip select |
| addr | input | 2 | Register address (00 data, 10 status, 11 control) |
| rdN | input | 1 | Active-low CPU read strobe |
| rdData | output | 8 | Read data for the addressed register |
| wrEn | input | 1 | Single-cycle control write pulse |
| wrData | input | 8 | Control write byte |
| gpIn | input | 2 | General-purpose line input levels |
| gpOut | output | 2 | General-purpose line output values |
| gpOe | output | 1 | General-purpose line output enable |

## Verification
Every one of the 256 byte values is sent through a complete strobe and read cycle with the mask set. A wrong capture, a stuck or crossed data bit, or a flag that clears early shows up as a mismatch on some value. A shorter sweep with the mask clear separates masking from the buffer-full logic. A second strobe of a different byte into a full buffer shows whether the latch is protected. A read with chip select high, and status reads in the middle of a transfer, show whether the clearing logic decodes address and select. Toggling the general-purpose direction and bits against gpIn shows which source feeds the upper status bits.

// File: rtl/strb_pkg.sv
package strb_pkg;
  localparam logic [1:0] ADDR_DATA = 2'b00;
  localparam logic [1:0] ADDR_STAT = 2'b10;
  localparam logic [1:0] ADDR_CTL  = 2'b11;
  localparam logic [2:0] SEL_MASK  = 3'd4;
  localparam logic [2:0] SEL_GP0   = 3'd6;
  localparam logic [2:0] SEL_GP1   = 3'd7;

  typedef struct packed {
    logic capture;
    logic gpBitWr;
    logic gpBitSel;
    logic gpBitVal;
    logic dirWr;
    logic dirVal;
  } dpCtl_t;
endpackage

// File: rtl/strb_ctrl.sv
module strb_ctrl
  import strb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stbN,
  input  logic       rdN,
  input  logic       csN,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output dpCtl_t     ctl,
  output logic       ibf,
  output logic       intr,
  output logic       inte
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] stbPipe, rdPipe;
  logic stbLowQ, rdLowQ;
  logic stbLowS, rdLowS;
  logic stbFall, rdFall, rdRise;
  logic dataRead, dataRdStart;
  logic ctlWr, bitWr;
  logic [2:0] bitSel;

  // Synchronizer chains, built by stage count
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stbPipe[i] <= 1'b0;
          rdPipe[i]  <= 1'b0;
        end else if (i == 0) begin
          stbPipe[i] <= ~stbN;
          rdPipe[i]  <= ~rdN;
        end else begin
          stbPipe[i] <= stbPipe[(i == 0) ? 0 : i - 1];
          rdPipe[i]  <= rdPipe[(i == 0) ? 0 : i - 1];
        end
      end
    end
  endgenerate

  assign stbLowS = stbPipe[LAST];
  assign rdLowS  = rdPipe[LAST];
  assign stbFall = stbLowS & ~stbLowQ;
  assign rdFall  = rdLowS & ~rdLowQ;
  assign rdRise  = ~rdLowS & rdLowQ;
  assign dataRdStart = rdFall & ~csN & (addr == ADDR_DATA);

  assign ctlWr  = wrEn & ~csN & (addr == ADDR_CTL);
  assign bitWr  = ctlWr & ~wrData[7];
  assign bitSel = wrData[3:1];

  always_comb begin
    ctl.capture  = stbFall & ~ibf;
    ctl.gpBitWr  = bitWr & ((bitSel == SEL_GP0) | (bitSel == SEL_GP1));
    ctl.gpBitSel = bitSel[0];
    ctl.gpBitVal = wrData[0];
    ctl.dirWr    = ctlWr & wrData[7];
    ctl.dirVal   = wrData[3];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbLowQ  <= 1'b0;
      rdLowQ   <= 1'b0;
      dataRead <= 1'b0;
      ibf      <= 1'b0;
      intr     <= 1'b0;
      inte     <= 1'b0;
    end else begin
      stbLowQ <= stbLowS;
      rdLowQ  <= rdLowS;
      if (dataRdStart)  dataRead <= 1'b1;
      else if (rdRise)  dataRead <= 1'b0;
      if (ctl.capture)              ibf <= 1'b1;
      else if (rdRise && dataRead)  ibf <= 1'b0;
      intr <= ~stbLowS & ibf & inte & ~dataRead & ~dataRdStart;
      if (bitWr && bitSel == SEL_MASK) inte <= wrData[0];
    end
  end
endmodule

// File: rtl/strb_datapath.sv
module strb_datapath
  import strb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] pinData,
  input  logic [1:0]        gpIn,
  input  logic [1:0]        addr,
  input  logic              ibf,
  input  logic              intr,
  input  logic              inte,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] latchQ,
  output logic [1:0]        gpOut,
  output logic              gpOe
);
  logic gpDirIn;
  logic [1:0] gpLevel;
  logic [7:0] statusByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ  <= '0;
      gpOut   <= '0;
      gpDirIn <= 1'b1;
    end else begin
      if (ctl.capture) latchQ <= pinData;
      if (ctl.dirWr)   gpDirIn <= ctl.dirVal;
      if (ctl.gpBitWr) gpOut[ctl.gpBitSel] <= ctl.gpBitVal;
    end
  end

  assign gpOe       = ~gpDirIn;
  assign gpLevel    = gpDirIn ? gpIn : gpOut;
  assign statusByte = {gpLevel, ibf, inte, intr, 3'b000};

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_DATA: rdData = latchQ;
      ADDR_STAT: rdData[7:0] = statusByte;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/strb_in_port.sv
module strb_in_port
  import strb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pinData,
  input  logic              stbN,
  output logic              ibfOut,
  output logic              intrOut,
  input  logic              csN,
  input  logic [1:0]        addr,
  input  logic              rdN,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic [1:0]        gpIn,
  output logic [1:0]        gpOut,
  output logic              gpOe
);
  dpCtl_t ctl;
  logic inteQ;
  logic [DATA_W-1:0] latchQ;

  strb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .stbN(stbN), .rdN(rdN), .csN(csN), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .ctl(ctl), .ibf(ibfOut), .intr(intrOut),
    .inte(inteQ)
  );

  strb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pinData(pinData), .gpIn(gpIn),
    .addr(addr), .ibf(ibfOut), .intr(intrOut), .inte(inteQ),
    .rdData(rdData), .latchQ(latchQ), .gpOut(gpOut), .gpOe(gpOe)
  );
endmodule

// File: rtl/strb_in_port_chk.sv
module strb_in_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ibfOut,
  input logic              intrOut,
  input logic              inteQ,
  input logic [DATA_W-1:0] latchQ
);
  AST_INTR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    intrOut |-> ibfOut); // R5
  AST_MASK_BLOCKS_INTR: assert property (@(posedge clk) disable iff (!rstN)
    !inteQ |=> !intrOut); // R7
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ibfOut && $past(ibfOut)) |-> $stable(latchQ)); // R4
  AST_INTR_GONE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ibfOut) |-> !intrOut); // R6
  AST_FLAG_RISE_NO_INTR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ibfOut) |-> !intrOut); // R3
endmodule

bind strb_in_port strb_in_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ibfOut(ibfOut), .intrOut(intrOut),
  .inteQ(inteQ), .latchQ(latchQ)
);

// File: tb/strb_in_port_test.sv
module strb_in_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinData = '0;
  logic stbN = 1'b1;
  logic ibfOut, intrOut;
  logic csN = 1'b1;
  logic [1:0] addr = 2'b00;
  logic rdN = 1'b1;
  logic [7:0] rdData;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] gpIn = 2'b10;
  logic [1:0] gpOut;
  logic gpOe;

  int checks = 0;
  int errors = 0;
  logic maskOn = 1'b0;

  always #4 clk = ~clk;

  strb_in_port uut (
    .clk(clk), .rstN(rstN), .pinData(pinData), .stbN(stbN), .ibfOut(ibfOut),
    .intrOut(intrOut), .csN(csN), .addr(addr), .rdN(rdN), .rdData(rdData),
    .wrEn(wrEn), .wrData(wrData), .gpIn(gpIn), .gpOut(gpOut), .gpOe(gpOe)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCtl(input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; addr = 2'b11; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; csN = 1'b1; addr = 2'b00;
    waitN(2);
  endtask

  task automatic strobe(input logic [7:0] v);
    pinData = v;
    stbN = 1'b0;
    waitN(6);
    check(ibfOut === 1'b1, "R3 flag after strobe", {7'b0, ibfOut}, 8'h01);
    check(intrOut === 1'b0, "R5 no intr with strobe low", {7'b0, intrOut}, 8'h00);
    stbN = 1'b1;
    waitN(5);
    if (maskOn)
      check(intrOut === 1'b1, "R5 intr after release", {7'b0, intrOut}, 8'h01);
    else
      check(intrOut === 1'b0, "R7 masked intr", {7'b0, intrOut}, 8'h00);
  endtask

  task automatic readData(input logic [7:0] exp);
    csN = 1'b0; addr = 2'b00; rdN = 1'b0;
    waitN(5);
    check(intrOut === 1'b0, "R6 intr cleared on read start", {7'b0, intrOut}, 8'h00);
    check(ibfOut === 1'b1, "R3 flag held during read", {7'b0, ibfOut}, 8'h01);
    check(rdData === exp, "R2 latched byte", rdData, exp);
    rdN = 1'b1;
    waitN(5);
    check(ibfOut === 1'b0, "R3 flag cleared after read", {7'b0, ibfOut}, 8'h00);
    csN = 1'b1;
  endtask

  task automatic readStatus(output logic [7:0] s);
    csN = 1'b0; addr = 2'b10; rdN = 1'b0;
    waitN(3);
    s = rdData;
    rdN = 1'b1;
    waitN(4);
    csN = 1'b1; addr = 2'b00;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] st;
    waitN(4);
    rstN = 1'b1;
    waitN(2);
    // R1 reset state
    check(ibfOut === 1'b0, "R1 flag at reset", {7'b0, ibfOut}, 8'h00);
    check(intrOut === 1'b0, "R1 intr at reset", {7'b0, intrOut}, 8'h00);
    check(gpOe === 1'b0, "R1 gp dir at reset", {7'b0, gpOe}, 8'h00);
    readStatus(st);
    check(st === 8'h80, "R1 status at reset", st, 8'h80);

    // R8 set the mask flip-flop
    writeCtl(8'h09);
    maskOn = 1'b1;
    readStatus(st);
    check(st === 8'h90, "R8 mask set in status", st, 8'h90);

    // Full sweep with the mask on
    for (int v = 0; v < 256; v++) begin
      strobe(v[7:0]);
      readData(v[7:0]);
    end

    // R9 status mid-transfer, not cleared by status read
    strobe(8'h3C);
    readStatus(st);
    check(st === 8'hB8, "R9 status full+mask+intr", st, 8'hB8);
    check(ibfOut === 1'b1, "R9 status read keeps flag", {7'b0, ibfOut}, 8'h01);
    // R11 read with chip select high is ignored
    csN = 1'b1; addr = 2'b00; rdN = 1'b0;
    waitN(5);
    rdN = 1'b1;
    waitN(5);
    check(ibfOut === 1'b1, "R11 deselected read keeps flag", {7'b0, ibfOut}, 8'h01);
    check(intrOut === 1'b1, "R11 deselected read keeps intr", {7'b0, intrOut}, 8'h01);
    // R4 strobe while full is ignored
    strobe(8'hC3);
    readData(8'h3C);

    // R7 masked sweep
    writeCtl(8'h08);
    maskOn = 1'b0;
    for (int v = 0; v < 16; v++) begin
      strobe(8'(v * 17));
      readStatus(st);
      check(st === 8'hA0, "R7 status full no intr", st, 8'hA0);
      readData(8'(v * 17));
    end

    // R10 general-purpose lines
    writeCtl(8'h80);
    check(gpOe === 1'b1, "R10 output dir", {7'b0, gpOe}, 8'h01);
    writeCtl(8'h0D);
    writeCtl(8'h0E);
    check(gpOut === 2'b01, "R10 gp bits", {6'b0, gpOut}, 8'h01);
    readStatus(st);
    check(st === 8'h40, "R10 status shows gpOut", st, 8'h40);
    writeCtl(8'h0F);
    check(gpOut === 2'b11, "R10 gp bit 7", {6'b0, gpOut}, 8'h03);
    writeCtl(8'h88);
    check(gpOe === 1'b0, "R10 input dir", {7'b0, gpOe}, 8'h00);
    gpIn = 2'b01;
    waitN(1);
    readStatus(st);
    check(st === 8'h40, "R10 status shows gpIn", st, 8'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule